// File: doc/BRIEF.md
# Flag-Setting Logical AND Execute Stage

This block decodes and executes the flag-setting bitwise AND whose second operand is a register that may be shifted first. One 32-bit instruction word enters with a valid strobe. The block presents the two source register indices on combinational outputs. An external register read port returns the two 64-bit source values in the same cycle. One clock later the block registers the destination index, the result, a register-write strobe and the four condition flags with a flag-write strobe. If the encoding is not one this block accepts, it raises an illegal-encoding strobe instead.

Bit 31 of the word selects between a 32-bit and a 64-bit operation. The second operand goes through a barrel shifter whose shift type and 6-bit amount come from the word. The shifted value is ANDed with the first operand. Negative and zero are computed at the selected width. Carry and overflow are always cleared. Register index 31 reads as zero on both sources. A write to index 31 is dropped, but the flags are still written.

Top module: `ands_alu_top`

## Requirements
- R1: An instruction is legal only when bits 30:29 are 2'b11, bits 28:24 are 5'b01010 and bit 21 is 0. A valid instruction that fails this test raises `illegal` one cycle later, with `regWe` and `flagWe` low, and leaves `resData`, `rdIdx` and the flags unchanged.
- R2: In the 32-bit variant (bit 31 = 0), a shift amount whose bit 15 is set is illegal and is handled as in R1.
- R3: Bits 23:22 choose the shift of the second operand: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The amount is bits 15:10, and only bits 14:10 are used in the 32-bit variant.
- R4: For a legal 64-bit instruction (bit 31 = 1), `resData` is the first source ANDed with the shifted second source.
- R5: For a legal 32-bit instruction, only bits 31:0 of each source are used. The shift acts within 32 bits and `resData[63:32]` is zero.
- R6: `flagN` equals bit 63 of the result for 64-bit operations and bit 31 for 32-bit operations.
- R7: `flagZ` is 1 exactly when the result at the selected width is zero.
- R8: `flagC` and `flagV` are 0 after every legal instruction.
- R9: Index 31 in bits 9:5 (first source) or bits 20:16 (second source) reads as zero, whatever the read port returns.
- R10: A legal instruction raises `flagWe`. It raises `regWe` only when bits 4:0 (`rdIdx`) are not 31.
- R11: Outputs are registered with one cycle of latency. During reset all outputs are zero. A cycle without `instValid` produces no strobe in the following cycle and keeps the held values.
- R12: `rnIdx` shows bits 9:5 and `rmIdx` shows bits 20:16 of `instWord` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction word is present this cycle |
| instWord | input | 32 | Instruction word |
| srcA | input | 64 | Value read for `rnIdx` |
| srcB | input | 64 | Value read for `rmIdx` |
| rnIdx | output | 5 | First source register index to the read port |
| rmIdx | output | 5 | Second source register index to the read port |
| rdIdx | output | 5 | Destination register index |
| resData | output | 64 | Result value |
| regWe | output | 1 | Register write strobe |
| flagWe | output | 1 | Flag write strobe |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| illegal | output | 1 | Illegal-encoding strobe |

## Verification
The bench uses the default `XLEN` of 64. That width brings up both shifter lanes: the full 64-bit lane with a 6-bit amount and the 32-bit lane with a 5-bit amount. Amounts of 0, 31, 32 and 63 are driven to reach the wrap-around edges of rotation and the sign fill of the arithmetic shift. Random words with corrupted fixed fields exercise the legality decode next to legal traffic. These words also include index 31 on every field.

// File: rtl/ands_pkg.sv
package ands_pkg;
  localparam int INST_W = 32;
  localparam int IDX_W = 5;
  localparam int SHAMT_W = 6;
  localparam logic [IDX_W-1:0] ZERO_REG = 5'd31;
  // opcode bits 30:24 must match this pattern for the class
  localparam logic [6:0] CLASS_PAT = 7'b1101010;

  typedef enum logic [1:0] {
    SHIFT_LSL = 2'b00,
    SHIFT_LSR = 2'b01,
    SHIFT_ASR = 2'b10,
    SHIFT_ROR = 2'b11
  } shiftKindE;

  typedef struct packed {
    logic              execStb;
    logic              badStb;
    logic              regWrStb;
    logic              wide;
    shiftKindE         kind;
    logic [SHAMT_W-1:0] shamt;
    logic              rnZero;
    logic              rmZero;
    logic [IDX_W-1:0]  rd;
  } aluCtrlT;
endpackage

// File: rtl/ands_shift_lane.sv
module ands_shift_lane
  import ands_pkg::*;
#(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  shiftKindE     kind,
  output logic [W-1:0]  dout
);
  logic [AW:0] backAmt;

  always_comb begin
    backAmt = (AW+1)'(W) - {1'b0, amt};
    unique case (kind)
      SHIFT_LSL: dout = din << amt;
      SHIFT_LSR: dout = din >> amt;
      SHIFT_ASR: dout = W'($signed(din) >>> amt);
      default:   dout = (din >> amt) | (din << backAmt);
    endcase
  end
endmodule

// File: rtl/ands_ctrl.sv
module ands_ctrl
  import ands_pkg::*;
(
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx,
  output aluCtrlT           ctrl
);
  logic wideOp;
  logic classOk;
  logic amtOk;
  logic legal;

  always_comb begin
    wideOp  = instWord[31];
    classOk = (instWord[30:24] == CLASS_PAT) && !instWord[21];
    amtOk   = wideOp || !instWord[15];
    legal   = classOk && amtOk;
    rnIdx   = instWord[9:5];
    rmIdx   = instWord[20:16];

    ctrl.execStb  = instValid && legal;
    ctrl.badStb   = instValid && !legal;
    ctrl.rd       = instWord[4:0];
    ctrl.regWrStb = (instWord[4:0] != ZERO_REG);
    ctrl.wide     = wideOp;
    ctrl.kind     = shiftKindE'(instWord[23:22]);
    ctrl.shamt    = instWord[15:10];
    ctrl.rnZero   = (instWord[9:5] == ZERO_REG);
    ctrl.rmZero   = (instWord[20:16] == ZERO_REG);
  end
endmodule

// File: rtl/ands_datapath.sv
module ands_datapath
  import ands_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int NLANE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrlT          ctrl,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [IDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]  resData,
  output logic             regWe,
  output logic             flagWe,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             illegal
);
  logic [XLEN-1:0] opA;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] opAm;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] andRes;
  logic [XLEN-1:0] laneOut [NLANE];
  logic            msb;
  logic            wideQ;

  always_comb begin
    opA = ctrl.rnZero ? '0 : srcA;
    opB = ctrl.rmZero ? '0 : srcB;
  end

  // lane 0 runs at full width, lane 1 at half width
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = XLEN >> g;
    localparam int LAW = $clog2(LW);
    logic [LW-1:0] laneRes;
    ands_shift_lane #(.W(LW)) u_lane (
      .din  (opB[LW-1:0]),
      .amt  (ctrl.shamt[LAW-1:0]),
      .kind (ctrl.kind),
      .dout (laneRes)
    );
    assign laneOut[g] = XLEN'(laneRes);
  end

  always_comb begin
    opAm    = ctrl.wide ? opA : XLEN'(opA[HALF-1:0]);
    shifted = ctrl.wide ? laneOut[0] : laneOut[1];
    andRes  = opAm & shifted;
    msb     = ctrl.wide ? andRes[XLEN-1] : andRes[HALF-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWe   <= 1'b0;
      flagWe  <= 1'b0;
      illegal <= 1'b0;
      rdIdx   <= '0;
      resData <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
      flagV   <= 1'b0;
      wideQ   <= 1'b0;
    end else begin
      regWe   <= ctrl.execStb && ctrl.regWrStb;
      flagWe  <= ctrl.execStb;
      illegal <= ctrl.badStb;
      if (ctrl.execStb) begin
        rdIdx   <= ctrl.rd;
        resData <= andRes;
        flagN   <= msb;
        flagZ   <= (andRes == '0);
        flagC   <= 1'b0;
        flagV   <= 1'b0;
        wideQ   <= ctrl.wide;
      end
    end
  end

  // R1: an illegal word never produces a write strobe
  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!regWe && !flagWe));

  p_no_zero_reg_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (rdIdx != ZERO_REG));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && flagWe) |-> (flagZ == (resData == '0)));

  p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && !wideQ) |-> (resData[XLEN-1:HALF] == '0));

  p_neg_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && wideQ) |-> (flagN == resData[XLEN-1]));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.execStb && !ctrl.badStb |=> (!regWe && !flagWe && !illegal));
endmodule

// File: rtl/ands_alu_top.sv
module ands_alu_top
  import ands_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [31:0]      instWord,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [4:0]       rnIdx,
  output logic [4:0]       rmIdx,
  output logic [4:0]       rdIdx,
  output logic [XLEN-1:0]  resData,
  output logic             regWe,
  output logic             flagWe,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV,
  output logic             illegal
);
  aluCtrlT ctrl;

  ands_ctrl u_ctrl (
    .instValid (instValid),
    .instWord  (instWord),
    .rnIdx     (rnIdx),
    .rmIdx     (rmIdx),
    .ctrl      (ctrl)
  );

  ands_datapath #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .rdIdx   (rdIdx),
    .resData (resData),
    .regWe   (regWe),
    .flagWe  (flagWe),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV),
    .illegal (illegal)
  );
endmodule

// File: tb/ands_alu_top_tb.sv
module ands_alu_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [4:0]  rnIdx, rmIdx, rdIdx;
  logic [63:0] resData;
  logic        regWe, flagWe, flagN, flagZ, flagC, flagV, illegal;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 0;

  // expected values for the cycle after the last drive
  logic [63:0] eRes = '0;
  logic [4:0]  eRd = '0;
  logic        eN = 0, eZ = 0, eRegWe = 0, eFlagWe = 0, eIll = 0;
  string       tagData = "R4";
  string       tagIll = "R1";

  always #4 clk = ~clk;

  ands_alu_top dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .rnIdx(rnIdx), .rmIdx(rmIdx), .rdIdx(rdIdx),
    .resData(resData), .regWe(regWe), .flagWe(flagWe), .flagN(flagN),
    .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInst(input bit sf, input int typ, input int rm,
                                         input int amt, input int rn, input int rd);
    logic [31:0] w;
    w = {sf, 2'b11, 5'b01010, 2'(typ), 1'b0, 5'(rm), 6'(amt), 5'(rn), 5'(rd)};
    return w;
  endfunction

  // R3: bitwise reference of the four shift kinds at width w
  function automatic logic [63:0] refShift(input logic [63:0] b, input int w,
                                           input int amt, input int typ);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < w; i++) begin
      int s;
      case (typ)
        0: begin s = i - amt; o[i] = (s >= 0) ? b[s] : 1'b0; end
        1: begin s = i + amt; o[i] = (s < w) ? b[s] : 1'b0; end
        2: begin s = i + amt; o[i] = (s < w) ? b[s] : b[w-1]; end
        default: o[i] = b[(i + amt) % w];
      endcase
    end
    return o;
  endfunction

  task automatic compareNow();
    chk("R10", "regWe", 64'(regWe), 64'(eRegWe));
    chk("R10", "flagWe", 64'(flagWe), 64'(eFlagWe));
    chk(tagIll, "illegal", 64'(illegal), 64'(eIll));
    chk(tagData, "resData", resData, eRes);
    chk("R11", "rdIdx", 64'(rdIdx), 64'(eRd));
    chk("R6", "flagN", 64'(flagN), 64'(eN));
    chk("R7", "flagZ", 64'(flagZ), 64'(eZ));
    chk("R8", "flagC", 64'(flagC), 64'b0);
    chk("R8", "flagV", 64'(flagV), 64'b0);
  endtask

  task automatic step(input bit v, input logic [31:0] w,
                      input logic [63:0] a, input logic [63:0] b);
    bit sf, legal;
    int rn, rm, amt, wd;
    logic [63:0] oa, ob, r;
    @(negedge clk);
    compareNow();
    instValid = v; instWord = w; srcA = a; srcB = b;
    #1;
    chk("R12", "rnIdx", 64'(rnIdx), 64'(w[9:5]));
    chk("R12", "rmIdx", 64'(rmIdx), 64'(w[20:16]));
    sf = w[31];
    rn = int'(w[9:5]); rm = int'(w[20:16]);
    legal = (w[30:29] == 2'b11) && (w[28:24] == 5'b01010) && !w[21] && (sf || !w[15]);
    tagIll = (!sf && w[15]) ? "R2" : "R1";
    eRegWe = 0; eFlagWe = 0; eIll = 0;
    if (v && !legal) eIll = 1;
    if (v && legal) begin
      wd  = sf ? 64 : 32;
      amt = sf ? int'(w[15:10]) : int'(w[14:10]);
      oa  = (rn == 31) ? 64'd0 : a;
      ob  = (rm == 31) ? 64'd0 : b;
      if (!sf) begin oa = {32'd0, oa[31:0]}; ob = {32'd0, ob[31:0]}; end
      r = oa & refShift(ob, wd, amt, int'(w[23:22]));
      eRes = r; eRd = w[4:0];
      eN = r[wd-1]; eZ = (r == 0);
      eFlagWe = 1; eRegWe = (w[4:0] != 5'd31);
      tagData = (rn == 31 || rm == 31) ? "R9" : (sf ? "R4" : "R5");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset regWe", 64'(regWe), 64'b0);
    chk("R11", "reset flagWe", 64'(flagWe), 64'b0);
    chk("R11", "reset illegal", 64'(illegal), 64'b0);
    chk("R11", "reset resData", resData, 64'b0);
    rstN = 1'b1;
    // R4/R3 64-bit shift kinds and edge amounts
    step(1, mkInst(1, 0, 2, 0, 1, 0), 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0);
    step(1, mkInst(1, 0, 2, 63, 1, 3), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    step(1, mkInst(1, 1, 2, 32, 1, 4), 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    step(1, mkInst(1, 2, 2, 63, 1, 5), 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    step(1, mkInst(1, 3, 2, 1, 1, 6), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    step(1, mkInst(1, 3, 2, 63, 1, 6), 64'hAAAA_AAAA_AAAA_AAAA, 64'h8000_0000_0000_0001);
    step(1, mkInst(1, 0, 2, 4, 1, 7), 64'h0F0F, 64'h0F0F);
    // R5: 32-bit with upper garbage, ASR and ROR within 32
    step(1, mkInst(0, 2, 2, 31, 1, 8), 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_8000_0000);
    step(1, mkInst(0, 3, 2, 4, 1, 9), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001);
    step(1, mkInst(0, 0, 2, 0, 1, 9), 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000);
    // R2: 32-bit amount with bit 5 set; 64-bit same amount is legal
    step(1, mkInst(0, 0, 2, 32, 1, 10), 64'h1, 64'h1);
    step(1, mkInst(1, 0, 2, 32, 1, 10), 64'hFFFF_FFFF_0000_0000, 64'h1);
    // R1: corrupted fixed fields
    step(1, mkInst(1, 0, 2, 0, 1, 11) | 32'h0020_0000, 64'hF, 64'hF);
    step(1, mkInst(1, 0, 2, 0, 1, 11) ^ 32'h4000_0000, 64'hF, 64'hF);
    step(1, mkInst(1, 0, 2, 0, 1, 11) ^ 32'h0100_0000, 64'hF, 64'hF);
    // R9 and R10: index 31 reads zero, write to 31 dropped
    step(1, mkInst(1, 0, 31, 0, 1, 12), 64'hFFFF, 64'hFFFF);
    step(1, mkInst(1, 0, 2, 0, 31, 12), 64'hFFFF, 64'hFFFF);
    step(1, mkInst(1, 0, 2, 0, 1, 31), 64'h8000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R11: idle cycles keep state
    step(0, mkInst(1, 0, 2, 0, 1, 13), 64'h0, 64'h0);
    step(0, 32'h0, 64'h0, 64'h0);
    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      w = mkInst(1'($urandom), int'($urandom % 4), int'($urandom % 32),
                 int'($urandom % 64), int'($urandom % 32), int'($urandom % 32));
      if ($urandom % 6 == 0) w = w ^ (32'h1 << (21 + ($urandom % 10)));
      step(1'($urandom % 5 != 0), w, {$urandom, $urandom}, {$urandom, $urandom});
    end
    step(0, 32'h0, 64'h0, 64'h0);
    @(negedge clk);
    compareNow();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule